// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit linear address into a physical address by walking a two-level page table held in memory. The walk starts from a root frame number. The walker reads the directory entry and then the second-level table entry over a word-wide request/acknowledge memory port. It checks the present, writable and user flags at both levels. On success it writes the accessed and dirty flags back into the entries. It then returns the physical address or reports a page fault. A fault report carries the faulting linear address and a three-bit error code.

The requester presents one request at a time. It raises `req_valid` while `busy` is low, and it waits for a one-cycle `done` or `fault` pulse. When paging is switched off, the address passes straight through and no memory is touched. The memory port carries whole little-endian entries: bits 7:0 of `mem_rdata` and `mem_wdata` are the byte at the lowest address of the entry.

The controller is one state machine with these states:
- `ST_IDLE` waits for a request.
- `ST_DIR_RD` and `ST_TBL_RD` hold a read until it is acknowledged.
- `ST_DIR_WB` and `ST_TBL_WB` hold an entry write-back until it is acknowledged.
- `ST_DONE` and `ST_FAULT` each last one cycle and report the outcome.

Its transitions are:
- IDLE→DIR_RD on a request with paging on.
- IDLE→DONE on a request with paging off.
- DIR_RD→TBL_RD on a present directory entry.
- DIR_RD→FAULT on an absent directory entry.
- TBL_RD→FAULT on an absent table entry or a permission violation.
- TBL_RD→DIR_WB when the directory entry needs its accessed flag.
- TBL_RD→TBL_WB when only the table entry changes.
- TBL_RD→DONE when neither entry changes.
- DIR_WB→TBL_WB or DIR_WB→DONE on acknowledge.
- TBL_WB→DONE on acknowledge.
- DONE→IDLE and FAULT→IDLE unconditionally.

Top module: `xlate_walker`

## Requirements
- R1: After reset `busy`, `done`, `fault` and `mem_req` are low, and `mem_req` is never high while `busy` is low.
- R2: With `paging_en` low, an accepted request gives `done` with `phys_addr` equal to the linear address in the cycle after acceptance, and makes no memory access.
- R3: The directory entry is read at {root_frame, lin[31:22], 2'b00}. The table entry is read at {directory entry bits 31:12, lin[21:12], 2'b00}. `phys_addr` is {table entry bits 31:12, lin[11:0]}.
- R4: An entry with bit 0 (present) clear at either level ends the walk with `fault`. The code then has bit 0 = 0, bit 1 = write access and bit 2 = user mode. `fault_addr` gets the linear address. An absent directory entry causes exactly one read.
- R5: A user access faults when bit 2 (user) is clear in either entry. A user write faults when bit 1 (writable) is clear in either entry. Such a fault has code bit 0 = 1 and bits 2:1 as in R4. Supervisor accesses ignore both flags.
- R6: A successful walk sets bit 5 (accessed) in both entries, and a write also sets bit 6 (dirty) in the table entry. An entry is written back only if it changes, with the directory before the table. A faulting walk writes nothing.
- R7: `busy` rises in the cycle after acceptance and stays high through the `done` or `fault` cycle. `req_valid` while `busy` is high has no effect.
- R8: `done` and `fault` are single-cycle pulses and never high together.
- R9: A memory request keeps `mem_req`, `mem_addr` and `mem_we` unchanged until `mem_ack`.
- R10: `fault_addr` changes only in a `fault` cycle and holds through later successful walks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request, taken while busy is low |
| req_lin_addr | input | 32 | Linear address to translate |
| req_write | input | 1 | 1 = write access, 0 = read |
| req_user | input | 1 | 1 = user mode, 0 = supervisor |
| paging_en | input | 1 | 1 = walk tables, 0 = identity mapping |
| root_frame | input | 20 | Frame number of the directory |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle success pulse |
| fault | output | 1 | One-cycle page-fault pulse |
| phys_addr | output | 32 | Translated address, valid with done |
| fault_addr | output | 32 | Linear address of the latest fault |
| fault_code | output | 3 | Error code of the latest fault |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the entry |
| mem_wdata | output | 32 | Entry value to write |
| mem_ack | input | 1 | Access complete; read data valid |
| mem_rdata | input | 32 | Entry value read |

## Verification
The bench targets the code split between an absent entry and a permission violation. A design that swapped them would report bit 0 wrongly for the directory-absent, table-absent, user-bit and writable-bit cases. It counts the write-backs and records their addresses. A design that always wrote back, or wrote the table first, would show an extra or misordered write. A design that marked pages dirty on reads would show a wrong table value. It checks that supervisor writes pass through read-only entries, that a request arriving mid-walk is dropped rather than queued, and that the fault address survives a later successful walk.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
    // flag positions inside a table entry
    localparam int FLG_PRESENT  = 0;
    localparam int FLG_WRITABLE = 1;
    localparam int FLG_USER     = 2;
    localparam int FLG_ACCESSED = 5;
    localparam int FLG_DIRTY    = 6;

    // error code bit positions
    localparam int CODE_W    = 3;
    localparam int CODE_PROT = 0;
    localparam int CODE_WR   = 1;
    localparam int CODE_USR  = 2;

    localparam int WALK_LEVELS = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIR_RD,
        ST_TBL_RD,
        ST_DIR_WB,
        ST_TBL_WB,
        ST_DONE,
        ST_FAULT
    } walk_state_e;
endpackage

// File: rtl/xlate_addr_gen.sv
module xlate_addr_gen #(
    parameter int IDX_W = 10,
    parameter int OFF_W = 12,
    localparam int AW = 2 * IDX_W + OFF_W,
    localparam int FR_W = AW - OFF_W,
    localparam int SEL_W = OFF_W - IDX_W
) (
    input  logic [FR_W-1:0] root_frame,
    input  logic [AW-1:0]   lin,
    input  logic [FR_W-1:0] dir_frame,
    input  logic [FR_W-1:0] tbl_frame,
    output logic [AW-1:0]   dir_ent_addr,
    output logic [AW-1:0]   tbl_ent_addr,
    output logic [AW-1:0]   phys
);
    localparam int TBL_LO = OFF_W;
    localparam int DIR_LO = OFF_W + IDX_W;

    logic [IDX_W-1:0] dir_idx;
    logic [IDX_W-1:0] tbl_idx;
    logic [OFF_W-1:0] pg_off;

    always_comb begin
        dir_idx      = lin[AW-1:DIR_LO];
        tbl_idx      = lin[DIR_LO-1:TBL_LO];
        pg_off       = lin[OFF_W-1:0];
        dir_ent_addr = {root_frame, dir_idx, {SEL_W{1'b0}}};
        tbl_ent_addr = {dir_frame, tbl_idx, {SEL_W{1'b0}}};
        phys         = {tbl_frame, pg_off};
    end
endmodule

// File: rtl/xlate_perm_chk.sv
module xlate_perm_chk #(
    parameter int LEVELS = 2
) (
    input  logic [LEVELS-1:0] usr_bits,
    input  logic [LEVELS-1:0] wr_bits,
    input  logic              is_write,
    input  logic              is_user,
    output logic              perm_ok
);
    logic [LEVELS-1:0] lvl_ok;

    for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
        always_comb begin
            lvl_ok[g] = 1'b1;
            if (is_user && !usr_bits[g])
                lvl_ok[g] = 1'b0;
            if (is_user && is_write && !wr_bits[g])
                lvl_ok[g] = 1'b0;
        end
    end

    assign perm_ok = &lvl_ok;
endmodule

// File: rtl/xlate_entry_upd.sv
module xlate_entry_upd
    import xlate_pkg::*;
#(
    parameter int EW = 32
) (
    input  logic [EW-1:0] entry_in,
    input  logic          mark_dirty,
    output logic [EW-1:0] entry_out,
    output logic          changed
);
    always_comb begin
        entry_out               = entry_in;
        entry_out[FLG_ACCESSED] = 1'b1;
        if (mark_dirty)
            entry_out[FLG_DIRTY] = 1'b1;
        changed = (entry_out != entry_in);
    end
endmodule

// File: rtl/xlate_walker.sv
module xlate_walker
    import xlate_pkg::*;
#(
    parameter int IDX_W = 10,
    parameter int OFF_W = 12,
    localparam int AW = 2 * IDX_W + OFF_W,
    localparam int FR_W = AW - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [AW-1:0]     req_lin_addr,
    input  logic              req_write,
    input  logic              req_user,
    input  logic              paging_en,
    input  logic [FR_W-1:0]   root_frame,
    output logic              busy,
    output logic              done,
    output logic              fault,
    output logic [AW-1:0]     phys_addr,
    output logic [AW-1:0]     fault_addr,
    output logic [CODE_W-1:0] fault_code,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [AW-1:0]     mem_wdata,
    input  logic              mem_ack,
    input  logic [AW-1:0]     mem_rdata
);
    walk_state_e state, nxt;

    logic [AW-1:0]     lin_q;
    logic              wr_q;
    logic              usr_q;
    logic [AW-1:0]     pde_q;
    logic [AW-1:0]     pte_q;
    logic [AW-1:0]     phys_q;
    logic [AW-1:0]     flt_addr_q;
    logic [CODE_W-1:0] flt_code_q;

    logic [AW-1:0] pte_cur;
    logic [AW-1:0] dir_ent_addr;
    logic [AW-1:0] tbl_ent_addr;
    logic [AW-1:0] phys_calc;
    logic          perm_ok;
    logic          flt_prot;
    logic [CODE_W-1:0] code_nxt;

    logic [WALK_LEVELS-1:0][AW-1:0] upd_in;
    logic [WALK_LEVELS-1:0][AW-1:0] upd_out;
    logic [WALK_LEVELS-1:0]         upd_dirty;
    logic [WALK_LEVELS-1:0]         upd_chg;
    logic [WALK_LEVELS-1:0]         lvl_usr;
    logic [WALK_LEVELS-1:0]         lvl_wr;

    // the table entry is examined straight off the read data in the read cycle
    assign pte_cur = (state == ST_TBL_RD) ? mem_rdata : pte_q;

    xlate_addr_gen #(.IDX_W(IDX_W), .OFF_W(OFF_W)) u_addr (
        .root_frame   (root_frame),
        .lin          (lin_q),
        .dir_frame    (pde_q[AW-1:OFF_W]),
        .tbl_frame    (pte_cur[AW-1:OFF_W]),
        .dir_ent_addr (dir_ent_addr),
        .tbl_ent_addr (tbl_ent_addr),
        .phys         (phys_calc)
    );

    assign upd_in[0]    = pde_q;
    assign upd_in[1]    = pte_cur;
    assign upd_dirty[0] = 1'b0;
    assign upd_dirty[1] = wr_q;

    for (genvar g = 0; g < WALK_LEVELS; g++) begin : g_upd
        xlate_entry_upd #(.EW(AW)) u_upd (
            .entry_in   (upd_in[g]),
            .mark_dirty (upd_dirty[g]),
            .entry_out  (upd_out[g]),
            .changed    (upd_chg[g])
        );
        assign lvl_usr[g] = upd_in[g][FLG_USER];
        assign lvl_wr[g]  = upd_in[g][FLG_WRITABLE];
    end

    xlate_perm_chk #(.LEVELS(WALK_LEVELS)) u_perm (
        .usr_bits (lvl_usr),
        .wr_bits  (lvl_wr),
        .is_write (wr_q),
        .is_user  (usr_q),
        .perm_ok  (perm_ok)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    // next state
    always_comb begin
        nxt      = state;
        flt_prot = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (req_valid)
                    nxt = paging_en ? ST_DIR_RD : ST_DONE;
            end
            ST_DIR_RD: begin
                if (mem_ack)
                    nxt = mem_rdata[FLG_PRESENT] ? ST_TBL_RD : ST_FAULT;
            end
            ST_TBL_RD: begin
                if (mem_ack) begin
                    if (!mem_rdata[FLG_PRESENT]) begin
                        nxt = ST_FAULT;
                    end else if (!perm_ok) begin
                        nxt      = ST_FAULT;
                        flt_prot = 1'b1;
                    end else if (upd_chg[0]) begin
                        nxt = ST_DIR_WB;
                    end else if (upd_chg[1]) begin
                        nxt = ST_TBL_WB;
                    end else begin
                        nxt = ST_DONE;
                    end
                end
            end
            ST_DIR_WB: begin
                if (mem_ack)
                    nxt = upd_chg[1] ? ST_TBL_WB : ST_DONE;
            end
            ST_TBL_WB: begin
                if (mem_ack)
                    nxt = ST_DONE;
            end
            ST_DONE:  nxt = ST_IDLE;
            ST_FAULT: nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        code_nxt            = '0;
        code_nxt[CODE_PROT] = flt_prot;
        code_nxt[CODE_WR]   = wr_q;
        code_nxt[CODE_USR]  = usr_q;
    end

    // walk registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lin_q      <= '0;
            wr_q       <= 1'b0;
            usr_q      <= 1'b0;
            pde_q      <= '0;
            pte_q      <= '0;
            phys_q     <= '0;
            flt_addr_q <= '0;
            flt_code_q <= '0;
        end else begin
            if (state == ST_IDLE && req_valid) begin
                lin_q  <= req_lin_addr;
                wr_q   <= req_write;
                usr_q  <= req_user;
                phys_q <= req_lin_addr;
            end
            if (state == ST_DIR_RD && mem_ack)
                pde_q <= mem_rdata;
            if (state == ST_TBL_RD && mem_ack) begin
                pte_q  <= mem_rdata;
                phys_q <= phys_calc;
            end
            if (nxt == ST_FAULT && state != ST_FAULT) begin
                flt_addr_q <= lin_q;
                flt_code_q <= code_nxt;
            end
        end
    end

    // outputs
    always_comb begin
        busy      = (state != ST_IDLE);
        done      = (state == ST_DONE);
        fault     = (state == ST_FAULT);
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        unique case (state)
            ST_DIR_RD: begin
                mem_req  = 1'b1;
                mem_addr = dir_ent_addr;
            end
            ST_TBL_RD: begin
                mem_req  = 1'b1;
                mem_addr = tbl_ent_addr;
            end
            ST_DIR_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = dir_ent_addr;
                mem_wdata = upd_out[0];
            end
            ST_TBL_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = tbl_ent_addr;
                mem_wdata = upd_out[1];
            end
            default: begin
                mem_req = 1'b0;
            end
        endcase
    end

    assign phys_addr  = phys_q;
    assign fault_addr = flt_addr_q;
    assign fault_code = flt_code_q;
endmodule

// File: rtl/xlate_walker_chk.sv
module xlate_walker_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic          busy,
    input logic          done,
    input logic          fault,
    input logic          mem_req,
    input logic          mem_we,
    input logic          mem_ack,
    input logic [AW-1:0] mem_addr,
    input logic [AW-1:0] fault_addr
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    // R7
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);

    // R7
    outcome_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done || fault) |-> busy);

    // R8
    one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fault));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    fault_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> !fault);

    // R9
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R10
    fault_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fault_addr) |-> fault);
endmodule

bind xlate_walker xlate_walker_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .busy       (busy),
    .done       (done),
    .fault      (fault),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_ack    (mem_ack),
    .mem_addr   (mem_addr),
    .fault_addr (fault_addr)
);

// File: tb/xlate_walker_test.sv
module xlate_walker_test;
    localparam int HALF = 10;   // 50 MHz
    localparam logic [19:0] ROOT = 20'h00001;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [31:0] req_lin_addr;
    logic        req_write;
    logic        req_user;
    logic        paging_en;
    logic        busy, done, fault;
    logic [31:0] phys_addr, fault_addr;
    logic [2:0]  fault_code;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack;
    logic [31:0] mem_rdata;

    int checks = 0;
    int failures = 0;

    always #HALF clk = ~clk;

    xlate_walker uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_lin_addr(req_lin_addr),
        .req_write(req_write), .req_user(req_user), .paging_en(paging_en),
        .root_frame(ROOT), .busy(busy), .done(done), .fault(fault),
        .phys_addr(phys_addr), .fault_addr(fault_addr), .fault_code(fault_code),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    // memory model: 16 KiB of words, answers one negedge after a request
    logic [31:0] mem [4096];
    logic        reload;
    int          rd_n, wr_n;
    logic [31:0] rd_addr0, wr_addr0, wr_addr1;

    always @(negedge clk) begin
        if (reload) begin
            for (int i = 0; i < 4096; i++) mem[i] = 32'h0;
            mem[1024 + 1] = 32'h0000_2007;
            mem[1024 + 2] = 32'h0000_3025;
            mem[1024 + 3] = 32'h0000_2023;
            mem[2048 + 3] = 32'hC425_C067;
            mem[2048 + 4] = 32'h0ABC_D007;
            mem[2048 + 5] = 32'h0001_2003;
            mem[2048 + 6] = 32'h0001_3005;
            mem[3072 + 1] = 32'h0055_5027;
            rd_n = 0; wr_n = 0;
            rd_addr0 = '0; wr_addr0 = '0; wr_addr1 = '0;
            mem_ack = 1'b0;
            mem_rdata = '0;
        end else if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            mem_ack = 1'b1;
            if (mem_we) begin
                mem[mem_addr[13:2]] = mem_wdata;
                if (wr_n == 0) wr_addr0 = mem_addr;
                if (wr_n == 1) wr_addr1 = mem_addr;
                wr_n++;
            end else begin
                mem_rdata = mem[mem_addr[13:2]];
                if (rd_n == 0) rd_addr0 = mem_addr;
                rd_n++;
            end
        end
    end

    // vector: lin, write, user, exp_fault, exp_code, exp_phys, exp_writes, exp_reads
    localparam int NV = 12;
    localparam logic [73:0] VEC [NV] = '{
        {32'h0040_3499, 1'b0, 1'b1, 1'b0, 3'd0, 32'hC425_C499, 2'd1, 2'd2},
        {32'h0040_4123, 1'b1, 1'b1, 1'b0, 3'd0, 32'h0ABC_D123, 2'd2, 2'd2},
        {32'h0080_1010, 1'b0, 1'b1, 1'b0, 3'd0, 32'h0055_5010, 2'd0, 2'd2},
        {32'h0080_1010, 1'b1, 1'b1, 1'b1, 3'd7, 32'h0,         2'd0, 2'd2},
        {32'h0080_1ABC, 1'b1, 1'b0, 1'b0, 3'd0, 32'h0055_5ABC, 2'd1, 2'd2},
        {32'h0000_5000, 1'b0, 1'b1, 1'b1, 3'd4, 32'h0,         2'd0, 2'd1},
        {32'h0040_7000, 1'b1, 1'b0, 1'b1, 3'd2, 32'h0,         2'd0, 2'd2},
        {32'h00C0_3020, 1'b0, 1'b1, 1'b1, 3'd5, 32'h0,         2'd0, 2'd2},
        {32'h00C0_3020, 1'b0, 1'b0, 1'b0, 3'd0, 32'hC425_C020, 2'd0, 2'd2},
        {32'h0040_5444, 1'b0, 1'b1, 1'b1, 3'd5, 32'h0,         2'd0, 2'd2},
        {32'h0040_6000, 1'b1, 1'b1, 1'b1, 3'd7, 32'h0,         2'd0, 2'd2},
        {32'h0040_6FF8, 1'b0, 1'b1, 1'b0, 3'd0, 32'h0001_3FF8, 2'd2, 2'd2}
    };

    task automatic chk(input logic ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic do_reload();
        @(negedge clk); reload = 1'b1;
        @(negedge clk);
        @(negedge clk); reload = 1'b0;
    endtask

    // issue one request and wait for the outcome; waited = negedges after acceptance
    task automatic run_walk(input logic [31:0] lin, input logic w, input logic u, output int waited);
        @(negedge clk);
        req_valid = 1'b1; req_lin_addr = lin; req_write = w; req_user = u;
        @(negedge clk);
        req_valid = 1'b0;
        waited = 0;
        for (int i = 0; i < 64 && !(done || fault); i++) begin
            @(negedge clk);
            waited++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures + 1);
        $finish;
    end

    initial begin
        int waited;
        logic [31:0] v_lin, v_phys, exp_dir;
        logic v_w, v_u, v_f;
        logic [2:0] v_code;
        int v_wr, v_rd;

        rst_n = 1'b0; req_valid = 1'b0; req_lin_addr = '0; req_write = 1'b0;
        req_user = 1'b0; paging_en = 1'b1; reload = 1'b1;
        repeat (4) @(negedge clk);
        reload = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(!busy && !done && !fault && !mem_req, "R1 idle after reset",
            {28'h0, busy, done, fault, mem_req}, 32'h0);

        // vector table
        for (int k = 0; k < NV; k++) begin
            {v_lin, v_w, v_u, v_f, v_code, v_phys} = VEC[k][73:4];
            v_wr = int'(VEC[k][3:2]);
            v_rd = int'(VEC[k][1:0]);
            exp_dir = {ROOT, v_lin[31:22], 2'b00};
            do_reload();
            run_walk(v_lin, v_w, v_u, waited);
            chk(fault == v_f && done == !v_f, $sformatf("R4/R5 outcome vec %0d", k),
                {30'h0, done, fault}, {30'h0, !v_f, v_f});
            if (v_f) begin
                chk(fault_code == v_code, $sformatf("R4/R5 code vec %0d", k),
                    {29'h0, fault_code}, {29'h0, v_code});
                chk(fault_addr == v_lin, $sformatf("R4 fault_addr vec %0d", k), fault_addr, v_lin);
            end else begin
                chk(phys_addr == v_phys, $sformatf("R3 phys vec %0d", k), phys_addr, v_phys);
            end
            chk(wr_n == v_wr, $sformatf("R6 write count vec %0d", k), wr_n, v_wr);
            chk(rd_n == v_rd, $sformatf("R4 read count vec %0d", k), rd_n, v_rd);
            chk(rd_addr0 == exp_dir, $sformatf("R3 directory address vec %0d", k), rd_addr0, exp_dir);
        end

        // R2 paging disabled: identity, no memory traffic, done right after acceptance
        do_reload();
        paging_en = 1'b0;
        run_walk(32'h1234_5678, 1'b1, 1'b1, waited);
        chk(done && waited == 0, "R2 done in cycle after acceptance", waited, 0);
        chk(phys_addr == 32'h1234_5678, "R2 identity phys", phys_addr, 32'h1234_5678);
        chk(rd_n + wr_n == 0, "R2 no memory access", rd_n + wr_n, 0);
        paging_en = 1'b1;

        // R6 write-back values and order for a user write
        do_reload();
        run_walk(32'h0040_4123, 1'b1, 1'b1, waited);
        chk(wr_addr0 == 32'h0000_1004, "R6 directory written first", wr_addr0, 32'h0000_1004);
        chk(wr_addr1 == 32'h0000_2010, "R6 table written second", wr_addr1, 32'h0000_2010);
        chk(mem[1024 + 1] == 32'h0000_2027, "R6 directory accessed set", mem[1024 + 1], 32'h0000_2027);
        chk(mem[2048 + 4] == 32'h0ABC_D067, "R6 table accessed and dirty set", mem[2048 + 4], 32'h0ABC_D067);

        // R6 read marks accessed only, never dirty
        do_reload();
        run_walk(32'h0040_6FF8, 1'b0, 1'b1, waited);
        chk(mem[2048 + 6] == 32'h0001_3025, "R6 read leaves dirty clear", mem[2048 + 6], 32'h0001_3025);

        // R6 faulting walk leaves memory untouched
        do_reload();
        run_walk(32'h0040_5444, 1'b0, 1'b1, waited);
        chk(mem[1024 + 1] == 32'h0000_2007, "R6 fault writes nothing", mem[1024 + 1], 32'h0000_2007);

        // R8 fault lasts one cycle; R10 fault_addr kept across a later success
        @(negedge clk);
        chk(!fault && !busy, "R8 fault single cycle", {30'h0, fault, busy}, 32'h0);
        do_reload();
        run_walk(32'h0000_5000, 1'b0, 1'b1, waited);
        do_reload();
        run_walk(32'h0080_1010, 1'b0, 1'b1, waited);
        chk(done && fault_addr == 32'h0000_5000, "R10 fault_addr held", fault_addr, 32'h0000_5000);

        // R7 request while busy is ignored
        do_reload();
        @(negedge clk);
        req_valid = 1'b1; req_lin_addr = 32'h0080_1010; req_write = 1'b0; req_user = 1'b1;
        @(negedge clk);
        req_lin_addr = 32'h0000_5000;       // stays valid during the walk
        chk(busy, "R7 busy after acceptance", {31'h0, busy}, 32'h1);
        for (int i = 0; i < 64 && !(done || fault); i++) @(negedge clk);
        req_valid = 1'b0;
        chk(done && busy && phys_addr == 32'h0055_5010, "R7 first request completes, busy in done cycle",
            phys_addr, 32'h0055_5010);
        @(negedge clk);
        chk(!busy && rd_n == 2, "R7 mid-walk request dropped", rd_n, 2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule